// File: doc/BRIEF.md
# Keystream XOR Stream Cipher Wrapper

This block encrypts or decrypts a byte message of any length by XORing each byte with keystream drawn from a separate ChaCha20 block generator. The same XOR serves both directions. A transfer starts with a one-cycle `start` pulse that loads the initial 128-bit counter (four 32-bit words, word 0 in bits 31:0) and the message length in bytes. Data then enters on a valid/ready byte stream and leaves, XORed, on a matching output stream.

The wrapper asks the generator for a 64-byte block each time it needs fresh keystream. It presents the counter to use and holds the request until the generator acknowledges it with the block. It uses every byte of a full block. A final block of 1 to 63 bytes uses only the leading bytes of its keystream. While a block is outstanding, input is back-pressured. When the last output byte has been taken, `done` pulses for one cycle and `final_ctr` holds the counter advanced past every block used. A zero-length message completes at once without requesting any keystream.

Top module: `chacha_stream_xor`

## Requirements
- R1: A `start` with `msg_len` = 0 raises `done` in the cycle after `start` is sampled. `final_ctr` then equals `init_ctr`, and `ks_req` is never raised.
- R2: Block n of a message (n counting from 0) is requested with `ks_ctr` word 0 (bits 31:0) equal to `init_ctr` word 0 + n modulo 2^32. Bits 127:32 equal those of `init_ctr`.
- R3: Output byte k equals input byte k XOR keystream byte (k mod 64) of block floor(k/64). Keystream byte j is `ks_data[8j+7:8j]`, so the bytes within each 32-bit word are taken least significant first.
- R4: A message of L bytes issues exactly ceil(L/64) keystream requests. A short final block uses only the first (L mod 64) bytes of its keystream.
- R5: `in_ready` is low whenever `ks_req` is high.
- R6: `out_last` is high on the final output byte of a message and low on every other output byte.
- R7: `done` pulses for one cycle, in the cycle after the handshake of the last output byte. `final_ctr` word 0 then equals `init_ctr` word 0 + ceil(L/64) modulo 2^32, and its upper words are unchanged.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_byte` and `out_last` hold their values into the next cycle.
- R9: Once raised, `ks_req` stays high with `ks_ctr` unchanged until the cycle in which `ks_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a message; sampled only when idle |
| init_ctr | input | 128 | Initial counter words, word 0 in bits 31:0 |
| msg_len | input | 32 | Message length in bytes |
| busy | output | 1 | A message is in progress |
| done | output | 1 | One-cycle pulse at message end |
| final_ctr | output | 128 | Counter after the message, valid with done |
| ks_req | output | 1 | Request for one keystream block |
| ks_ctr | output | 128 | Counter words for the requested block |
| ks_ack | input | 1 | Generator returns a block this cycle |
| ks_data | input | 512 | Keystream block, byte j at bits 8j+7:8j |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Wrapper accepts an input byte |
| in_byte | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the output byte |
| out_byte | output | 8 | XORed byte |
| out_last | output | 1 | Final byte of the message |

## Verification
The embedded properties check the cycle-level rules on every clock: input is blocked while a block request is open, a request and its counter stay fixed until acknowledged, a stalled output byte does not change, and `done` lasts a single cycle. Whether each byte carries the right keystream byte, whether tails use only a prefix of a block, and whether the right number of requests and the right final counter appear can only be shown by the bench's scenarios. These cover lengths 0, 1, 63, 64, 65 and 130, counter wrap in word 0, and random output stalls.

// File: rtl/chacha_stream_xor.sv
`timescale 1ns/1ps
module chacha_stream_xor #(
  parameter int BLK_BYTES = 64,
  parameter int LEN_W     = 32,
  parameter int CTR_W     = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [CTR_W-1:0]       init_ctr,
  input  logic [LEN_W-1:0]       msg_len,
  output logic                   busy,
  output logic                   done,
  output logic [CTR_W-1:0]       final_ctr,
  output logic                   ks_req,
  output logic [CTR_W-1:0]       ks_ctr,
  input  logic                   ks_ack,
  input  logic [BLK_BYTES*8-1:0] ks_data,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [7:0]             in_byte,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [7:0]             out_byte,
  output logic                   out_last
);
  localparam int IW = $clog2(BLK_BYTES);
  localparam logic [IW-1:0] IDX_END = IW'(BLK_BYTES - 1);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_RUN, S_FLUSH} st_t;

  st_t                   st;
  logic [CTR_W-1:0]      ctr;
  logic [LEN_W-1:0]      remain;
  logic [IW-1:0]         idx;
  logic [BLK_BYTES*8-1:0] ks;
  logic                  take;
  logic [7:0]            ks_byte;

  assign busy      = (st != S_IDLE);
  assign ks_req    = (st == S_FETCH);
  assign ks_ctr    = ctr;
  assign final_ctr = ctr;
  assign in_ready  = (st == S_RUN) && (!out_valid || out_ready);
  assign take      = in_valid && in_ready;
  assign ks_byte   = ks[idx*8 +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ctr       <= '0;
      remain    <= '0;
      idx       <= '0;
      ks        <= '0;
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_last  <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          ctr    <= init_ctr;
          remain <= msg_len;
          idx    <= '0;
          if (msg_len == '0) done <= 1'b1;
          else               st   <= S_FETCH;
        end
        S_FETCH: if (ks_ack) begin
          ks          <= ks_data;
          idx         <= '0;
          ctr[31:0]   <= ctr[31:0] + 32'd1;
          st          <= S_RUN;
        end
        S_RUN: if (take) begin
          out_byte  <= in_byte ^ ks_byte;
          out_last  <= (remain == LEN_W'(1));
          out_valid <= 1'b1;
          remain    <= remain - LEN_W'(1);
          idx       <= idx + IW'(1);
          if (remain == LEN_W'(1)) st <= S_FLUSH;
          else if (idx == IDX_END) st <= S_FETCH;
        end
        S_FLUSH: if (out_valid && out_ready) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5
  no_input_while_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ks_req |-> !in_ready);

  // R9
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_req && !ks_ack) |=> (ks_req && $stable(ks_ctr)));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> done);
endmodule

// File: tb/test_chacha_stream_xor.sv
`timescale 1ns/1ps
module test_chacha_stream_xor;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] init_ctr = '0;
  logic [31:0]  msg_len = '0;
  logic         busy, done;
  logic [127:0] final_ctr;
  logic         ks_req;
  logic [127:0] ks_ctr;
  logic         ks_ack = 1'b0;
  logic [511:0] ks_data = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [7:0]   in_byte = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [7:0]   out_byte;
  logic         out_last;

  int checks = 0;
  int fails  = 0;
  int nreq   = 0;
  int r5_bad = 0;
  bit stall_en = 1'b0;
  logic [127:0] base_ctr = '0;
  logic [8:0]   q[$];
  logic [15:0]  lfsr = 16'hACE1;

  always #2 clk = ~clk;

  chacha_stream_xor i_chacha_stream_xor (
    .clk(clk), .rst_n(rst_n), .start(start), .init_ctr(init_ctr), .msg_len(msg_len),
    .busy(busy), .done(done), .final_ctr(final_ctr), .ks_req(ks_req), .ks_ctr(ks_ctr),
    .ks_ack(ks_ack), .ks_data(ks_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_last(out_last));

  function automatic logic [7:0] ksb(logic [31:0] w0, int j);
    return 8'(w0[7:0] * 8'd29 + 8'(j * 7) + 8'h5A) ^ w0[15:8];
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // keystream generator model
  initial begin
    forever begin
      @(posedge clk); #1;
      ks_ack = 1'b0;
      if (ks_req) begin
        logic [127:0] c0;
        c0 = ks_ctr;
        for (int w = 0; w < 2; w++) begin
          @(posedge clk); #1;
          chk(ks_req && ks_ctr == c0, "R9", ks_ctr, c0);
        end
        chk(ks_ctr == {base_ctr[127:32], base_ctr[31:0] + 32'(nreq)}, "R2", ks_ctr,
            {base_ctr[127:32], base_ctr[31:0] + 32'(nreq)});
        for (int j = 0; j < 64; j++) ks_data[8*j +: 8] = ksb(ks_ctr[31:0], j);
        ks_ack = 1'b1;
        nreq++;
      end
    end
  end

  // output back-pressure
  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = stall_en ? lfsr[0] : 1'b1;
    end
  end

  // monitor: scoreboard pop, stall stability, input blocking
  logic       held = 1'b0;
  logic [8:0] held_v = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ks_req && in_ready) r5_bad++;
      if (held) chk(out_valid && {out_last, out_byte} == held_v, "R8", {out_valid, out_last, out_byte}, {1'b1, held_v});
      held   = out_valid && !out_ready;
      held_v = {out_last, out_byte};
      if (out_valid && out_ready) begin
        if (q.size() == 0) chk(1'b0, "R3", {out_last, out_byte}, 0);
        else begin
          logic [8:0] e;
          e = q.pop_front();
          chk(out_byte == e[7:0], "R3", out_byte, e[7:0]);
          chk(out_last == e[8], "R6", out_last, e[8]);
        end
      end
    end
  end

  task automatic run_msg(int len, logic [127:0] ic, bit stall, int m);
    int blocks;
    int wd;
    blocks   = (len + 63) / 64;
    stall_en = stall;
    base_ctr = ic;
    nreq     = 0;
    r5_bad   = 0;
    @(posedge clk); #1;
    start = 1'b1; init_ctr = ic; msg_len = 32'(len);
    @(posedge clk); #1;
    start = 1'b0;
    for (int k = 0; k < len; k++) begin
      in_valid = 1'b1;
      in_byte  = 8'(k * 13 + m * 3 + 1);
      forever begin @(negedge clk); if (in_ready) break; end
      q.push_back({(k == len - 1), in_byte ^ ksb(ic[31:0] + 32'(k / 64), k % 64)});
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    wd = 0;
    forever begin
      @(negedge clk);
      if (done || wd > 2000) break;
      wd++;
    end
    chk(done, "R7", done, 1);
    chk(final_ctr == {ic[127:32], ic[31:0] + 32'(blocks)}, "R7", final_ctr,
        {ic[127:32], ic[31:0] + 32'(blocks)});
    chk(nreq == blocks, "R4", nreq, blocks);
    chk(q.size() == 0, "R3", q.size(), 0);
    chk(r5_bad == 0, "R5", r5_bad, 0);
    @(negedge clk);
    chk(!done && !busy, "R7", {done, busy}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !out_valid && !ks_req && !in_ready, "R1",
        {busy, done, out_valid, ks_req, in_ready}, 0);
    // R1 zero length
    run_msg(0, 128'h0123_4567_89AB_CDEF_0011_2233_0000_0007, 1'b0, 0);
    chk(nreq == 0, "R1", nreq, 0);
    run_msg(1, 128'h1, 1'b0, 1);
    run_msg(63, 128'hDEAD_BEEF_0000_0000_0000_0000_0000_0010, 1'b1, 2);
    run_msg(64, 128'h5, 1'b0, 3);
    run_msg(65, 128'h7777_0000_0000_0000_0000_0000_0000_0020, 1'b1, 4);
    run_msg(130, 128'h9, 1'b1, 5);
    // R2 word 0 wraps without carrying into word 1
    run_msg(70, 128'h0000_0001_0000_0002_0000_0003_FFFF_FFFF, 1'b0, 6);
    run_msg(0, 128'h42, 1'b1, 7);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule